// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 64 level-sensitive interrupt requests and presents one interrupt line to a processor. Each source carries an enable flag and a 4-bit priority. Software reaches the controller through a plain 32-bit word-addressed register port. A source is switched on or off by writing its number to a dedicated register, so no read-modify-write of a bitmask is needed. A global threshold register holds back every source whose priority does not exceed it.

A combinational arbitration tree picks the winner every cycle. The winner is the highest priority among eligible sources, and a tie goes to the larger source number. The result is captured in a vector status word. Software reads that word to learn which source to service and at what level. When nothing is eligible the word reads as a negative number, so a handler can loop on it until it turns negative. The interrupt output is registered alongside the vector word.

Word addresses: 0x00 threshold, 0x01 enable-by-number, 0x02 disable-by-number, 0x03 vector status, 0x08 to 0x0F priority words.

Top module: `prio_intc`

## Requirements
- R1: After reset all enables are clear, all priority fields and the threshold are zero, `irq` is low and the vector word (address 0x03) reads 0xFFFFFFFF.
- R2: A write of value n to address 0x01 sets the enable of source n only. A write whose full 32-bit value is 64 or more changes no enable.
- R3: A write of value n to address 0x02 clears the enable of source n only. A write whose full 32-bit value is 64 or more changes no enable.
- R4: The priority of source n occupies bits [(n mod 8)*4 +: 4] of the word at address 0x0F − n/8. Each priority word is fully readable and writable.
- R5: The threshold register at address 0x00 holds wdata[3:0] on a write, and it reads back with bits [31:4] as zero.
- R6: A source is eligible only while its request is high, its enable is set and its priority is strictly greater than the threshold.
- R7: Among eligible sources the highest priority wins. Among equal priorities the higher source number wins.
- R8: The vector word holds the winning source number in bits [31:16] and its priority in bits [15:0], both zero-extended. It reads 0xFFFFFFFF when no source is eligible.
- R9: `irq` is high exactly when a source was eligible at the previous clock edge. `irq` and the vector word both update one clock edge after any change on the request inputs, and two edges after a register write.
- R10: Requests are level-sensitive and nothing is latched. A source stops being reported as soon as its request falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_req | input | 64 | Level-sensitive request per source |
| irq | output | 1 | Interrupt to the processor |

## Verification
Two functions can land on the same clock edge. One is a register write: an enable, a disable or a threshold change. The other is a change on the request inputs. The bench provokes this by driving a disable of the current winner, or a new threshold, during the same cycle in which other requests rise or fall. It then judges the vector word two edges later against its own arithmetic model. That model applies the write first and then re-arbitrates over the new request pattern. The same model also scores exhaustive sweeps over every source number and every threshold value.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    // Word addresses of the register port
    localparam int OFS_THRESH   = 8'h00;
    localparam int OFS_EN_NUM   = 8'h01;
    localparam int OFS_DIS_NUM  = 8'h02;
    localparam int OFS_VECTOR   = 8'h03;
    // Priority words run downward from this address, group 0 on top
    localparam int OFS_PRIO_TOP = 8'h0F;
    localparam int REG_W        = 32;
    localparam int HALF_W       = 16;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [REG_W-1:0]            wdata,
    output logic [NUM_SRC-1:0]          en_q,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    output logic [PRIO_W-1:0]           thresh_q,
    output logic [REG_W-1:0]            rd_word
);
    localparam int ID_W    = $clog2(NUM_SRC);
    localparam int PER_REG = REG_W / PRIO_W;
    localparam int NUM_GRP = NUM_SRC / PER_REG;

    logic            num_ok;
    logic [ID_W-1:0] wnum;
    logic            hit_en;
    logic            hit_dis;
    logic            hit_thr;

    assign num_ok  = (wdata < REG_W'(NUM_SRC));
    assign wnum    = wdata[ID_W-1:0];
    assign hit_en  = wr_en && num_ok && (addr == ADDR_W'(OFS_EN_NUM));
    assign hit_dis = wr_en && num_ok && (addr == ADDR_W'(OFS_DIS_NUM));
    assign hit_thr = wr_en && (addr == ADDR_W'(OFS_THRESH));

    // Per-source enable flags, touched one number at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (hit_en) begin
            en_q[wnum] <= 1'b1;
        end else if (hit_dis) begin
            en_q[wnum] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_q <= '0;
        end else if (hit_thr) begin
            thresh_q <= wdata[PRIO_W-1:0];
        end
    end

    // Priority words, group g placed g words below the top address
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int GADDR = OFS_PRIO_TOP - g;
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (addr == ADDR_W'(GADDR))) begin
                word_q <= wdata;
            end
        end
        assign prio_flat[g*REG_W +: REG_W] = word_q;
    end

    // Read mux for the storage registers
    always_comb begin
        rd_word = '0;
        if (addr == ADDR_W'(OFS_THRESH)) begin
            rd_word = {{(REG_W-PRIO_W){1'b0}}, thresh_q};
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (addr == ADDR_W'(OFS_PRIO_TOP - g)) begin
                rd_word = prio_flat[g*REG_W +: REG_W];
            end
        end
    end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thresh,
    output logic                      win_valid,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio
);
    localparam int LVLS = ID_W;

    // Level 0 holds one leaf per source; each later level halves the count
    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int CNT = NUM_SRC >> l;
        logic [CNT-1:0]        v;
        logic [CNT*PRIO_W-1:0] p;
        logic [CNT*ID_W-1:0]   n;

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < CNT; i++) begin : g_src
                logic [PRIO_W-1:0] pr;
                assign pr = prio_flat[i*PRIO_W +: PRIO_W];
                assign v[i] = req[i] && en[i] && (pr > thresh);
                assign p[i*PRIO_W +: PRIO_W] = pr;
                assign n[i*ID_W +: ID_W] = ID_W'(i);
            end
        end else begin : g_merge
            for (genvar i = 0; i < CNT; i++) begin : g_node
                logic              lv, rv, take_r;
                logic [PRIO_W-1:0] lp, rp;
                assign lv = g_lvl[l-1].v[2*i];
                assign rv = g_lvl[l-1].v[2*i+1];
                assign lp = g_lvl[l-1].p[(2*i)*PRIO_W +: PRIO_W];
                assign rp = g_lvl[l-1].p[(2*i+1)*PRIO_W +: PRIO_W];
                // Upper half holds higher numbers, so it wins ties
                assign take_r = rv && (!lv || (rp >= lp));
                assign v[i] = lv || rv;
                assign p[i*PRIO_W +: PRIO_W] = take_r ? rp : lp;
                assign n[i*ID_W +: ID_W] = take_r ? g_lvl[l-1].n[(2*i+1)*ID_W +: ID_W]
                                                  : g_lvl[l-1].n[(2*i)*ID_W +: ID_W];
            end
        end
    end

    assign win_valid = g_lvl[LVLS].v[0];
    assign win_prio  = g_lvl[LVLS].p[PRIO_W-1:0];
    assign win_id    = g_lvl[LVLS].n[ID_W-1:0];
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic               irq
);
    localparam int ID_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]        en_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [PRIO_W-1:0]         thresh_q;
    logic [REG_W-1:0]          reg_rd;
    logic                      win_valid;
    logic [ID_W-1:0]           win_id;
    logic [PRIO_W-1:0]         win_prio;
    logic [REG_W-1:0]          vec_q;
    logic                      irq_q;

    prio_intc_regs #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .en_q      (en_q),
        .prio_flat (prio_flat),
        .thresh_q  (thresh_q),
        .rd_word   (reg_rd)
    );

    prio_intc_arb #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .req       (src_req),
        .en        (en_q),
        .prio_flat (prio_flat),
        .thresh    (thresh_q),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    // Vector word and interrupt line are captured together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '1;
            irq_q <= 1'b0;
        end else begin
            vec_q <= win_valid ? {HALF_W'(win_id), HALF_W'(win_prio)} : '1;
            irq_q <= win_valid;
        end
    end

    assign irq   = irq_q;
    assign rdata = (addr == ADDR_W'(OFS_VECTOR)) ? vec_q : reg_rd;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [31:0]                 wdata,
    input logic [NUM_SRC-1:0]          src_req,
    input logic [NUM_SRC-1:0]          en_q,
    input logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    input logic [PRIO_W-1:0]           thresh_q,
    input logic [31:0]                 vec_q,
    input logic                        irq
);
    localparam int ID_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]        elig;
    logic [NUM_SRC-1:0]        elig_d;
    logic [NUM_SRC*PRIO_W-1:0] prio_d;
    logic [PRIO_W-1:0]         best_p;
    logic [ID_W-1:0]           best_n;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = src_req[i] && en_q[i] && (prio_flat[i*PRIO_W +: PRIO_W] > thresh_q);
        end
    end

    always_ff @(posedge clk) begin
        elig_d <= elig;
        prio_d <= prio_flat;
    end

    always_comb begin
        best_p = '0;
        best_n = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig_d[i] && (prio_d[i*PRIO_W +: PRIO_W] >= best_p)) begin
                best_p = prio_d[i*PRIO_W +: PRIO_W];
                best_n = ID_W'(i);
            end
        end
    end

    a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |=> irq);
    a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(|elig) |=> !irq);
    a_r8_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec_q == 32'hFFFF_FFFF));
    a_r8_busy_positive: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !vec_q[31]);
    a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> elig_d[vec_q[16 +: ID_W]]);
    a_r7_highest_prio: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec_q[15:0] == 16'(best_p)));
    a_r7_tie_upper: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec_q[31:16] == 16'(best_n)));
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_EN_NUM) && wdata < 32'(NUM_SRC))
        |=> en_q[$past(wdata[ID_W-1:0])]);
    a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DIS_NUM) && wdata < 32'(NUM_SRC))
        |=> !en_q[$past(wdata[ID_W-1:0])]);
    a_r2_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(en_q ^ $past(en_q)) <= 1));
endmodule

bind prio_intc prio_intc_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .src_req   (src_req),
    .en_q      (en_q),
    .prio_flat (prio_flat),
    .thresh_q  (thresh_q),
    .vec_q     (vec_q),
    .irq       (irq)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NS-1:0] src_req = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit [NS-1:0] en_m;
    logic [3:0]  prio_m [NS];
    logic [3:0]  thr_m;

    always #2 clk = ~clk;

    prio_intc dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .src_req (src_req),
        .irq     (irq)
    );

    function automatic logic [31:0] model(input logic [NS-1:0] rq);
        int best = -1;
        logic [3:0] bp = '0;
        for (int i = 0; i < NS; i++) begin
            if (rq[i] && en_m[i] && prio_m[i] > thr_m && (best < 0 || prio_m[i] >= bp)) begin
                best = i;
                bp = prio_m[i];
            end
        end
        if (best < 0) return 32'hFFFF_FFFF;
        return {16'(best), 12'h000, bp};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_vec(input string tag);
        logic [31:0] v;
        logic [31:0] e;
        settle();
        e = model(src_req);
        rd(8'h03, v);
        chk(tag, v, e);
        chk(tag, {31'd0, irq}, {31'd0, e != 32'hFFFF_FFFF});
    endtask

    task automatic load_prio();
        for (int g = 0; g < NS/8; g++) begin
            logic [31:0] w = '0;
            for (int j = 0; j < 8; j++) w[j*4 +: 4] = prio_m[g*8+j];
            wr(8'(8'h0F - g), w);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        en_m = '0;
        thr_m = '0;
        for (int i = 0; i < NS; i++) prio_m[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 threshold", v, 32'h0);
        rd(8'h03, v); chk("R1 vector", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        for (int g = 0; g < 8; g++) begin
            rd(8'(8'h0F - g), v); chk("R1 prio word", v, 32'h0);
        end

        // R5 threshold readback, upper bits dropped
        wr(8'h00, 32'hFFFF_FFF5);
        rd(8'h00, v); chk("R5 threshold", v, 32'h5);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R5 threshold clear", v, 32'h0);

        // R4 priority layout: program and read back each word
        for (int i = 0; i < NS; i++) prio_m[i] = 4'((i*5 + 3) % 16);
        load_prio();
        for (int g = 0; g < 8; g++) begin
            logic [31:0] w = '0;
            for (int j = 0; j < 8; j++) w[j*4 +: 4] = prio_m[g*8+j];
            rd(8'(8'h0F - g), v); chk("R4 prio readback", v, w);
        end

        // R2 R3 R4 R8 per-source sweep
        for (int s = 0; s < NS; s++) begin
            wr(8'h01, 32'(s)); en_m[s] = 1'b1;
            src_req = '0; src_req[s] = 1'b1;
            check_vec("R2 R4 R8 single source");
            wr(8'h02, 32'(s)); en_m[s] = 1'b0;
            check_vec("R3 single disable");
        end

        // R2 out-of-range numbers ignored
        src_req = '0; src_req[5] = 1'b1;
        wr(8'h01, 32'd69);
        wr(8'h01, 32'h0000_0105);
        check_vec("R2 out of range enable");
        wr(8'h01, 32'd5); en_m[5] = 1'b1;
        wr(8'h02, 32'h0001_0005);
        check_vec("R3 out of range disable");

        for (int s = 0; s < NS; s++) begin
            wr(8'h01, 32'(s)); en_m[s] = 1'b1;
        end

        // R7 arbitration over many patterns
        src_req = '1;
        check_vec("R7 all requests");
        src_req = '0; src_req[12] = 1'b1; src_req[28] = 1'b1;
        check_vec("R7 tie upper wins");
        for (int k = 0; k < 40; k++) begin
            src_req = {$urandom, $urandom} & {$urandom, $urandom};
            check_vec("R7 pattern");
        end

        // R6 threshold sweep
        src_req = '1;
        for (int m = 0; m < 16; m++) begin
            wr(8'h00, 32'(m)); thr_m = 4'(m);
            check_vec("R6 threshold sweep");
        end
        wr(8'h00, 32'h0); thr_m = '0;

        // R3 disable one by one
        for (int s = NS-1; s >= 0; s--) begin
            wr(8'h02, 32'(s)); en_m[s] = 1'b0;
            check_vec("R3 staged disable");
        end
        for (int s = 0; s < NS; s++) begin
            wr(8'h01, 32'(s)); en_m[s] = 1'b1;
        end

        // R10 level sensitivity
        src_req = '0; src_req[33] = 1'b1;
        check_vec("R10 held");
        src_req = '0;
        check_vec("R10 released");

        // R9 one-edge latency from request to irq
        @(negedge clk);
        src_req[12] = 1'b1;
        #1; chk("R9 not yet", {31'd0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 one edge", {31'd0, irq}, 32'h1);
        src_req = '0;

        // Same cycle: disable winner while requests change
        src_req = '0; src_req[60] = 1'b1;
        check_vec("R7 before race");
        @(negedge clk);
        src_req = '0; src_req[60] = 1'b1; src_req[12] = 1'b1; src_req[7] = 1'b1;
        wr_en = 1'b1; addr = 8'h02; wdata = 32'd60; en_m[60] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check_vec("R3 R7 disable with request change");

        // Same cycle: threshold write while requests rise
        @(negedge clk);
        src_req = '1;
        wr_en = 1'b1; addr = 8'h00; wdata = 32'd14; thr_m = 4'd14;
        @(negedge clk);
        wr_en = 1'b0;
        check_vec("R6 threshold with request change");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule